// File: doc/BRIEF.md
# Serial Audio Codec Port

This block connects an on-chip audio path to an external codec over a three-wire serial audio link: a bit clock, a frame sync and one data line in each direction. It can own the link and generate the bit clock and frame sync from the system clock. It can also follow a bit clock and frame sync driven by the codec, after synchronising them into the system clock domain. Each frame has a left slot and a right slot, each one word long. Frame sync low marks the left slot. The word length is chosen at run time as 8, 16, 24 or 32 bits.

Two framing variants are supported. In the standard variant the most significant bit comes one bit clock after the frame-sync edge. In the left-justified variant it starts with that edge. In stereo mode every slot carries its own word. In mono mode the transmitter repeats the left word in the right slot, and the receiver keeps only the left slot.

Each direction has an eight-word buffer. Each buffer has a threshold interrupt and a request line that a DMA engine can use. A transmit buffer that runs dry sends zeros and sets a sticky flag. A receive buffer that is full drops the arriving word and sets a separate sticky flag.

Top module: `i2s_port`

## Requirements
- R1: As clock master (`cfg_master`=1, `en`=1), `bclk_o` toggles every `HALF_DIV` system clocks, starting low. `fs_o` changes only in the cycle where `bclk_o` falls. A frame lasts 2×word-length bit clocks, with `fs_o` low for the left slot and high for the right slot. `clk_out_en` is 1.
- R2: As clock slave (`cfg_master`=0), the port follows `bclk_i` and `fs_i` through a synchroniser. It starts transferring at the first frame-sync edge it sees after `en` rises. It drives `bclk_o`, `fs_o` and `clk_out_en` low.
- R3: `cfg_width` selects the word length: 0 gives 8 bits, 1 gives 16, 2 gives 24, 3 gives 32. FIFO words are right-justified. On the wire each word is sent most significant bit first, and bits above the word length are ignored.
- R4: With `cfg_msbj`=0 the MSB of a slot is in the bit period that follows the first one after the frame-sync edge. With `cfg_msbj`=1 the MSB is in the first bit period after that edge.
- R5: `sdo` changes only when the bit clock falls. Received data is sampled when the bit clock rises.
- R6: With `cfg_mono`=1, each transmit word is sent in both the left and right slot and popped once. Only left-slot words are written to the receive FIFO.
- R7: Each FIFO holds 8 words. A write to a full transmit FIFO and a read of an empty receive FIFO are ignored. `tx_level`, `rx_level`, `tx_full` and `rx_empty` report occupancy.
- R8: `tx_irq` is 1 whenever `tx_level` ≤ `tx_thr`. `rx_irq` is 1 whenever `rx_level` ≥ `rx_thr`.
- R9: `tx_dma_req` is 1 while `en`=1 and the transmit FIFO is not full. `rx_dma_req` is 1 while the receive FIFO is not empty.
- R10: When a slot starts with the transmit FIFO empty, zeros are sent for that slot and `tx_underflow` is set. It stays set until `flags_clr`.
- R11: When a received word completes with the receive FIFO full, the word is dropped and `rx_overflow` is set. It stays set until `flags_clr`.
- R12: After reset, both levels are 0, both flags are 0, and `sdo` and `bclk_o` are 0. In master mode `fs_o` is 1, so the first left slot produces a frame-sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Link enable; low returns the serial engine to idle |
| cfg_master | input | 1 | 1 = generate bit clock and frame sync |
| cfg_msbj | input | 1 | 1 = left-justified framing, 0 = standard framing |
| cfg_mono | input | 1 | 1 = mono |
| cfg_width | input | 2 | Word length code |
| tx_thr | input | 4 | Transmit threshold |
| rx_thr | input | 4 | Receive threshold |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| tx_data | input | 32 | Transmit word |
| tx_level | output | 4 | Transmit FIFO occupancy |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_data | output | 32 | Head of receive FIFO |
| rx_level | output | 4 | Receive FIFO occupancy |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| flags_clr | input | 1 | Clears both sticky flags |
| bclk_i | input | 1 | External bit clock (slave) |
| fs_i | input | 1 | External frame sync (slave) |
| sdi | input | 1 | Serial data in |
| bclk_o | output | 1 | Generated bit clock (master) |
| fs_o | output | 1 | Generated frame sync (master) |
| sdo | output | 1 | Serial data out |
| clk_out_en | output | 1 | Drive enable for bit clock and frame sync pins |

## Verification
The assertions check the following on every cycle:
- frame sync and serial data move only on a falling bit-clock event;
- a master rising event is followed by a high bit clock;
- a full FIFO ignores a write, and an empty FIFO ignores a read;
- both error flags stay set until they are cleared.

Only the bench scenarios can show the rest:
- the bit-exact contents of every slot under each framing, width and mono/stereo combination;
- that slave timing locks to the external frame sync;
- that zeros fill a dry transmit slot;
- that exactly the first eight words survive a receive overflow.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        WL_8  = 2'd0,
        WL_16 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

    typedef struct packed {
        logic  master;
        logic  msbj;
        logic  mono;
        wlen_e width;
    } port_cfg_t;

    // Bit-clock events seen in the system clock domain.
    typedef struct packed {
        logic rise;
        logic fall;
        logic fs;
        logic din;
    } bit_evt_t;

    function automatic logic [6:0] slot_bits(wlen_e w);
        case (w)
            WL_8:    return 7'd8;
            WL_16:   return 7'd16;
            WL_24:   return 7'd24;
            default: return 7'd32;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] word_mask(wlen_e w);
        case (w)
            WL_8:    return 32'h0000_00FF;
            WL_16:   return 32'h0000_FFFF;
            WL_24:   return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/i2s_port_fifo.sv
module i2s_port_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rp];
    assign level = cnt;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= nxt(wp);
            if (do_rd) rp <= nxt(rp);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    // R7: a write into a full buffer leaves it full
    a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd) |=> (level == CW'(DEPTH)));
    // R7: a read from an empty buffer leaves it empty
    a_r7_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (empty && rd && !wr) |=> (level == '0));

endmodule

// File: rtl/i2s_port_clkgen.sv
module i2s_port_clkgen
    import i2s_port_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DW         = $clog2(HALF_DIV + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     master,
    input  logic     bclk_i,
    input  logic     fs_i,
    input  logic     sdi,
    output logic     bclk_o,
    output bit_evt_t evt
);
    logic [2:0]    raw;
    logic [2:0]    synced;
    logic          bclk_d;
    logic          bclk_q;
    logic [DW-1:0] divcnt;
    logic          tick;

    assign raw = {bclk_i, fs_i, sdi};

    // One synchroniser chain per incoming line.
    for (genvar g = 0; g < 3; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) bclk_d <= 1'b0;
        else     bclk_d <= synced[2];
    end

    assign tick = en && master && (divcnt == DW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || !master) begin
            divcnt <= '0;
            bclk_q <= 1'b0;
        end else if (tick) begin
            divcnt <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            divcnt <= divcnt + DW'(1);
        end
    end

    always_comb begin
        evt.fs  = synced[1];
        evt.din = synced[0];
        if (master) begin
            evt.rise = tick && !bclk_q;
            evt.fall = tick &&  bclk_q;
        end else begin
            evt.rise = en &&  synced[2] && !bclk_d;
            evt.fall = en && !synced[2] &&  bclk_d;
        end
    end

    assign bclk_o = master && bclk_q;

    // R1: a master rising event is followed by a high bit clock
    a_r1_rise_sets_bclk: assert property (@(posedge clk) disable iff (rst || !en || !master)
        evt.rise |=> bclk_o);
    // R1: the generated clock holds between divider ticks
    a_r1_bclk_holds: assert property (@(posedge clk) disable iff (rst || !en || !master)
        !(evt.rise || evt.fall) |=> $stable(bclk_o));

endmodule

// File: rtl/i2s_port_serdes.sv
module i2s_port_serdes
    import i2s_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  port_cfg_t         cfg,
    input  bit_evt_t          evt,
    output logic              tx_pop,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_empty,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              rx_full,
    output logic              fs_o,
    output logic              sdo,
    output logic              unf_set,
    output logic              ovf_set
);
    logic [6:0]        pos, pos_n, d_q, d_n, wb, fb, r_idx;
    logic              fs_q, fs_seen, locked, lock_n;
    logic              fall_go, rise_go, start_n, right_n, r_right;
    logic              ld, needs_new, rx_armed, rx_done;
    logic [WORD_W-1:0] tx_sh, rx_sh, left_hold, new_word;

    assign wb      = slot_bits(cfg.width);
    assign fb      = wb << 1;
    assign fall_go = en && evt.fall;

    // Frame position and data position after the falling edge.
    always_comb begin
        lock_n = locked;
        if (cfg.master) begin
            pos_n  = (pos >= fb - 7'd1) ? 7'd0 : pos + 7'd1;
            lock_n = 1'b1;
        end else if (evt.fs != fs_seen) begin
            pos_n  = evt.fs ? wb : 7'd0;
            lock_n = 1'b1;
        end else begin
            pos_n  = (pos >= fb - 7'd1) ? 7'd0 : pos + 7'd1;
        end
        if (cfg.msbj) d_n = pos_n;
        else          d_n = (pos_n == 7'd0) ? fb - 7'd1 : pos_n - 7'd1;
        right_n = (d_n >= wb);
        start_n = (d_n == 7'd0) || (d_n == wb);
    end

    assign ld        = fall_go && lock_n && start_n;
    assign needs_new = !right_n || !cfg.mono;
    assign tx_pop    = ld && needs_new && !tx_empty;
    assign unf_set   = ld && needs_new &&  tx_empty;
    always_comb begin
        if (!needs_new)    new_word = left_hold;
        else if (tx_empty) new_word = '0;
        else               new_word = tx_word;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pos       <= 7'h7F;
            d_q       <= '0;
            fs_q      <= 1'b1;
            fs_seen   <= evt.fs;
            locked    <= 1'b0;
            tx_sh     <= '0;
            left_hold <= '0;
        end else if (fall_go) begin
            pos     <= pos_n;
            d_q     <= d_n;
            fs_q    <= (pos_n >= wb);
            fs_seen <= evt.fs;
            locked  <= lock_n;
            if (ld) begin
                tx_sh <= new_word << (7'd32 - wb);
                if (!right_n) left_hold <= new_word;
            end else if (lock_n) begin
                tx_sh <= tx_sh << 1;
            end
        end
    end

    assign sdo  = tx_sh[WORD_W-1];
    assign fs_o = cfg.master && fs_q;

    // Receive side: sampled on rising edges, slot position from d_q.
    assign rise_go = en && evt.rise && locked;
    assign r_right = (d_q >= wb);
    assign r_idx   = r_right ? d_q - wb : d_q;
    assign rx_word = {rx_sh[WORD_W-2:0], evt.din} & word_mask(cfg.width);
    assign rx_done = rise_go && rx_armed && (r_idx == wb - 7'd1) && (!cfg.mono || !r_right);
    assign rx_push = rx_done && !rx_full;
    assign ovf_set = rx_done &&  rx_full;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rx_sh    <= '0;
            rx_armed <= 1'b0;
        end else if (rise_go) begin
            rx_sh <= {rx_sh[WORD_W-2:0], evt.din};
            if (r_idx == 7'd0) rx_armed <= 1'b1;
        end
    end

    // R5: serial output moves only on a falling event
    a_r5_sdo_on_fall: assert property (@(posedge clk) disable iff (rst || !en)
        !evt.fall |=> $stable(sdo));
    // R1: frame sync moves only on a falling event
    a_r1_fs_on_fall: assert property (@(posedge clk) disable iff (rst || !en)
        !evt.fall |=> $stable(fs_o));
    // R6: mono right slots never pop the transmit buffer
    a_r6_mono_single_pop: assert property (@(posedge clk) disable iff (rst)
        (cfg.mono && ld && right_n) |-> !tx_pop);

endmodule

// File: rtl/i2s_port.sv
module i2s_port
    import i2s_port_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH       = 8,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cfg_master,
    input  logic          cfg_msbj,
    input  logic          cfg_mono,
    input  logic [1:0]    cfg_width,
    input  logic [CW-1:0] tx_thr,
    input  logic [CW-1:0] rx_thr,
    input  logic          tx_wr,
    input  logic [31:0]   tx_data,
    output logic [CW-1:0] tx_level,
    output logic          tx_full,
    input  logic          rx_rd,
    output logic [31:0]   rx_data,
    output logic [CW-1:0] rx_level,
    output logic          rx_empty,
    output logic          tx_irq,
    output logic          rx_irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          tx_underflow,
    output logic          rx_overflow,
    input  logic          flags_clr,
    input  logic          bclk_i,
    input  logic          fs_i,
    input  logic          sdi,
    output logic          bclk_o,
    output logic          fs_o,
    output logic          sdo,
    output logic          clk_out_en
);
    port_cfg_t         cfg;
    bit_evt_t          evt;
    logic              tx_pop, tx_empty, rx_push, rx_full, unf_set, ovf_set;
    logic [WORD_W-1:0] tx_head, rx_word;

    assign cfg = '{master: cfg_master, msbj: cfg_msbj, mono: cfg_mono,
                   width: wlen_e'(cfg_width)};

    i2s_port_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .wr(tx_wr), .wdata(tx_data), .rd(tx_pop),
        .rdata(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty));

    i2s_port_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .wr(rx_push), .wdata(rx_word), .rd(rx_rd),
        .rdata(rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty));

    i2s_port_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk(clk), .rst(rst), .en(en), .master(cfg_master),
        .bclk_i(bclk_i), .fs_i(fs_i), .sdi(sdi), .bclk_o(bclk_o), .evt(evt));

    i2s_port_serdes u_ser (
        .clk(clk), .rst(rst), .en(en), .cfg(cfg), .evt(evt),
        .tx_pop(tx_pop), .tx_word(tx_head), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_word(rx_word), .rx_full(rx_full),
        .fs_o(fs_o), .sdo(sdo), .unf_set(unf_set), .ovf_set(ovf_set));

    always_ff @(posedge clk) begin
        if (rst || flags_clr) begin
            tx_underflow <= 1'b0;
            rx_overflow  <= 1'b0;
        end else begin
            if (unf_set) tx_underflow <= 1'b1;
            if (ovf_set) rx_overflow  <= 1'b1;
        end
    end

    assign tx_irq     = (tx_level <= tx_thr);
    assign rx_irq     = (rx_level >= rx_thr);
    assign tx_dma_req = en && !tx_full;
    assign rx_dma_req = !rx_empty;
    assign clk_out_en = cfg_master;

    // R10: underflow flag stays until cleared
    a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (tx_underflow && !flags_clr) |=> tx_underflow);
    // R11: overflow flag stays until cleared
    a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_overflow && !flags_clr) |=> rx_overflow);
    // R11: a dropped word leaves the receive level unchanged
    a_r11_drop_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (ovf_set && !rx_rd) |=> $stable(rx_level));

endmodule

// File: tb/i2s_port_test.sv
module i2s_port_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        en = 0, cfg_master = 1, cfg_msbj = 0, cfg_mono = 0;
    logic [1:0]  cfg_width = 2'd1;
    logic [3:0]  tx_thr = 4'd2, rx_thr = 4'd4;
    logic        tx_wr = 0, rx_rd = 0, flags_clr = 0;
    logic [31:0] tx_data = '0;
    logic [3:0]  tx_level, rx_level;
    logic        tx_full, rx_empty, tx_irq, rx_irq, tx_dma_req, rx_dma_req;
    logic        tx_underflow, rx_overflow;
    logic [31:0] rx_data;
    logic        bclk_drv = 0, fs_drv = 1, sdi = 0;
    logic        bclk_o, fs_o, sdo, clk_out_en;

    i2s_port uut (
        .clk(clk), .rst(rst), .en(en), .cfg_master(cfg_master), .cfg_msbj(cfg_msbj),
        .cfg_mono(cfg_mono), .cfg_width(cfg_width), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_level(tx_level), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_level(rx_level), .rx_empty(rx_empty),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow), .flags_clr(flags_clr),
        .bclk_i(bclk_drv), .fs_i(fs_drv), .sdi(sdi), .bclk_o(bclk_o), .fs_o(fs_o),
        .sdo(sdo), .clk_out_en(clk_out_en));

    int vectors = 0, miscompares = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: words queued in the bench's view of each buffer.
    logic [31:0] mtx[$], mrx[$], codec_q[$];
    bit exp_unf = 0, exp_ovf = 0;

    // Codec model state.
    bit run = 0, started = 0, cur_right = 0, bcl = 0;
    int p = 0, fsl = 1, cur_idx = 0, slots_done = 0;
    int gcnt = 0, gpos = 0;
    localparam int GHALF = 8;
    logic [31:0] ex_word, ex_left, cw_in;

    function automatic int wl();
        return 8 * (int'(cfg_width) + 1);
    endfunction

    function automatic logic [31:0] wmask();
        return (wl() == 32) ? 32'hFFFF_FFFF : ((32'h1 << wl()) - 32'h1);
    endfunction

    always @(negedge clk) begin
        if (run) begin
            int w, f, d;
            bit bc, fsv;
            w = wl();
            f = 2 * w;
            if (!cfg_master) begin
                gcnt++;
                if (gcnt == GHALF) begin
                    gcnt = 0;
                    bclk_drv = ~bclk_drv;
                    if (!bclk_drv) begin
                        gpos = (gpos + 1) % f;
                        fs_drv = (gpos >= w);
                    end
                end
            end
            bc  = cfg_master ? bclk_o : bclk_drv;
            fsv = cfg_master ? fs_o : fs_drv;
            if (!bc && bcl) begin
                if (int'(fsv) != fsl) p = fsv ? w : 0;
                else p = (p + 1 >= f) ? 0 : p + 1;
                fsl = fsv;
                d = cfg_msbj ? p : ((p == 0) ? f - 1 : p - 1);
                cur_idx = d % w;
                if (cur_idx == 0) begin
                    started = 1;
                    cur_right = (d >= w);
                    if (!cur_right || !cfg_mono) begin
                        if (mtx.size() > 0) ex_word = mtx.pop_front();
                        else begin ex_word = '0; exp_unf = 1; end
                        if (!cur_right) ex_left = ex_word;
                    end else ex_word = ex_left;
                    cw_in = (codec_q.size() > 0) ? codec_q.pop_front() : 32'h0;
                end
                sdi = started ? cw_in[w-1-cur_idx] : 1'b0;
            end
            if (bc && !bcl && started) begin
                // R3 R4 R5 R6 R10: bit-exact wire check
                chk("R4 sdo bit", {31'h0, sdo}, {31'h0, ex_word[w-1-cur_idx]});
                if (cur_idx == w - 1) begin
                    slots_done++;
                    if (!cfg_mono || !cur_right) begin
                        if (mrx.size() < 8) mrx.push_back(cw_in & wmask());
                        else exp_ovf = 1;
                    end
                end
            end
            bcl = bc;
        end
    end

    task automatic push_tx(input logic [31:0] wv);
        tx_wr = 1; tx_data = wv;
        if (mtx.size() < 8) mtx.push_back(wv);
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic run_scn(input bit m, input bit mj, input bit mo, input logic [1:0] ws,
                           input int nsl, input int tail);
        cfg_master = m; cfg_msbj = mj; cfg_mono = mo; cfg_width = ws;
        @(negedge clk);
        started = 0; p = 0; fsl = 1; bcl = 0; slots_done = 0;
        gcnt = 0; gpos = 2 * wl() - 1; bclk_drv = 0; fs_drv = 1;
        repeat (4) @(negedge clk);
        run = 1; en = 1;
        @(negedge clk);
        // R9: transmit request follows enable and fullness
        chk("R9 tx_dma_req", {31'h0, tx_dma_req}, {31'h0, !tx_full});
        // R1 R2: pin drive enable follows the clock role
        chk("R2 clk_out_en", {31'h0, clk_out_en}, {31'h0, m});
        while (slots_done < nsl) @(negedge clk);
        repeat (tail) @(negedge clk);
        en = 0; run = 0;
        bclk_drv = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_scn(input string tag);
        chk({tag, " R7 tx_level"}, {28'h0, tx_level}, mtx.size());
        chk({tag, " R7 rx_level"}, {28'h0, rx_level}, mrx.size());
        chk({tag, " R10 tx_underflow"}, {31'h0, tx_underflow}, {31'h0, exp_unf});
        chk({tag, " R11 rx_overflow"}, {31'h0, rx_overflow}, {31'h0, exp_ovf});
        chk({tag, " R8 rx_irq"}, {31'h0, rx_irq}, {31'h0, mrx.size() >= int'(rx_thr)});
        chk({tag, " R9 rx_dma_req"}, {31'h0, rx_dma_req}, {31'h0, mrx.size() != 0});
        while (mrx.size() > 0) begin
            chk({tag, " R3 rx_data"}, rx_data, mrx.pop_front());
            rx_rd = 1;
            @(negedge clk);
            rx_rd = 0;
        end
        flags_clr = 1;
        @(negedge clk);
        flags_clr = 0;
        @(negedge clk);
        exp_unf = 0; exp_ovf = 0;
        chk({tag, " R11 flags cleared"}, {30'h0, tx_underflow, rx_overflow}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset state
        chk("R12 tx_level", {28'h0, tx_level}, 32'h0);
        chk("R12 rx_empty", {31'h0, rx_empty}, 32'h1);
        chk("R12 flags", {30'h0, tx_underflow, rx_overflow}, 32'h0);
        chk("R12 sdo/bclk", {30'h0, sdo, bclk_o}, 32'h0);
        chk("R12 fs_o", {31'h0, fs_o}, 32'h1);
        chk("R8 tx_irq empty", {31'h0, tx_irq}, 32'h1);
        chk("R9 tx_dma_req idle", {31'h0, tx_dma_req}, 32'h0);
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
        @(negedge clk);
        // R7: read of empty buffer ignored
        chk("R7 empty read", {28'h0, rx_level}, 32'h0);

        // Scenario 1: master, standard framing, stereo, 16-bit; underflow at the end.
        for (int i = 0; i < 4; i++) push_tx(32'hA5A0_1230 + 32'(i * 32'h1111));
        chk("R8 tx_irq above threshold", {31'h0, tx_irq}, 32'h0);
        for (int i = 0; i < 6; i++) codec_q.push_back(32'h0000_C001 + 32'(i * 32'h0777));
        run_scn(1'b1, 1'b0, 1'b0, 2'd1, 6, 2);
        finish_scn("S1");

        // Scenario 2: master, left-justified, mono, 24-bit.
        for (int i = 0; i < 3; i++) push_tx(32'h00F1_2345 + 32'(i * 32'h0102_0304));
        for (int i = 0; i < 6; i++) codec_q.push_back(32'h0012_3456 + 32'(i * 32'h0011_1111));
        run_scn(1'b1, 1'b1, 1'b1, 2'd2, 6, 2);
        finish_scn("S2 R6");

        // Scenario 3: slave, standard framing, stereo, 8-bit; full write, overflow.
        for (int i = 0; i < 9; i++) push_tx(32'h0000_0081 + 32'(i * 7));
        chk("R7 tx_full", {31'h0, tx_full}, 32'h1);
        chk("R7 tx_level capped", {28'h0, tx_level}, 32'h8);
        for (int i = 0; i < 12; i++) codec_q.push_back(32'h0000_0030 + 32'(i * 13));
        run_scn(1'b0, 1'b0, 1'b0, 2'd0, 12, 5);
        chk("R2 slave bclk_o low", {30'h0, bclk_o, fs_o}, 32'h0);
        finish_scn("S3 R2");

        // Scenario 4: slave, left-justified, stereo, 32-bit.
        for (int i = 0; i < 4; i++) push_tx(32'h8000_0001 ^ 32'(i * 32'h1357_9BDF));
        for (int i = 0; i < 4; i++) codec_q.push_back(32'hF00D_0000 + 32'(i * 32'h0101_0101));
        run_scn(1'b0, 1'b1, 1'b0, 2'd3, 4, 5);
        finish_scn("S4 R3");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule